// File: doc/BRIEF.md
# Coprocessor Array Issue Controller

This controller sits between an in-order processor pipeline and a reconfigurable compute array that acts as a coprocessor. The processor presents one command at a time. A select command names a configuration tag. A push command hands two operand words and a 16-bit cycle budget to the array. A pull command retrieves the array's result word. The controller accepts a command on any cycle in which `cmd_valid_i` is high and `stall_o` is low. A command offered while `stall_o` is high simply waits.

The controller tracks residency in two places. One slot holds the active configuration, and a small cache of `NCACHE` entries holds configurations that are loaded but not active. Selecting the active tag costs nothing. Selecting a cached tag swaps it in with a fixed `SWAP_LAT`-cycle stall, and the displaced active tag takes over the cache entry that was hit. Selecting any other tag raises a load request and waits for the load-done handshake. The displaced active tag then enters the cache at a round-robin slot.

A push starts the array and loads a down-counter with the supplied budget. The processor stays stalled until the counter reaches zero, and at that point the array result is captured. Data commands issued with nothing resident are dropped, and they set a sticky error flag.

Top module: `cpa_issue_ctrl`

## Requirements
- R1: After reset, `stall_o`, `err_o`, `cfg_load_req_o` and `rd_valid_o` are 0, and no configuration is resident.
- R2: Commands are encoded on `cmd_op_i` as 0 = none, 1 = select, 2 = push, 3 = pull. A command is accepted only in a cycle where `cmd_valid_i`=1 and `stall_o`=0.
- R3: Selecting the tag that is already active is accepted with no stall. `stall_o` stays 0 in the following cycle.
- R4: Selecting a cached, non-active tag holds `stall_o` high for exactly `SWAP_LAT` (default 4) cycles after acceptance. The tag then drives `arr_cfg_o`, and the previous active tag becomes cached.
- R5: Selecting a tag that is neither active nor cached raises `cfg_load_req_o` with `cfg_load_tag_o` equal to the tag, starting the cycle after acceptance. `stall_o` stays high up to and including the cycle in which `cfg_load_done_i` is 1. The tag is then active. A previously active tag is kept in the cache, with entries filled round-robin.
- R6: An accepted push with a configuration resident pulses `arr_start_o` in the same cycle. In that cycle `arr_op_a_o` and `arr_op_b_o` carry the two operand inputs and `arr_cfg_o` carries the active tag.
- R7: After a push with budget C > 0, `stall_o` is high for exactly the C following cycles. With C = 0, `stall_o` is not raised.
- R8: The result register captures `arr_result_i` in the last stalled cycle of an operation. For C = 0 it captures it in the accept cycle. An accepted pull sets `rd_valid_o` with `rd_data_o` equal to that register in the next cycle.
- R9: A pull offered while an operation runs is held. It completes on the first cycle after the counter expires, and `rd_valid_o` stays 0 in the meantime.
- R10: The result register keeps its value across cycles until the next operation completes, so repeated pulls return the same word.
- R11: A push or pull accepted with no configuration resident produces no `arr_start_o` and no `rd_valid_o`. It sets `err_o` on the next cycle, and `err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | Command code |
| cmd_cfg_i | input | CFG_W | Configuration tag for select |
| cmd_a_i | input | DATA_W | First operand word for push |
| cmd_b_i | input | DATA_W | Second operand word for push |
| cmd_cycles_i | input | CNT_W | Cycle budget for push |
| stall_o | output | 1 | Processor stall |
| err_o | output | 1 | Sticky no-configuration error |
| rd_valid_o | output | 1 | Pull result valid |
| rd_data_o | output | DATA_W | Pull result word |
| arr_start_o | output | 1 | Array operation start pulse |
| arr_cfg_o | output | CFG_W | Active configuration tag |
| arr_op_a_o | output | DATA_W | First operand to array |
| arr_op_b_o | output | DATA_W | Second operand to array |
| arr_result_i | input | DATA_W | Array result word |
| cfg_load_req_o | output | 1 | Configuration load request |
| cfg_load_tag_o | output | CFG_W | Tag to load |
| cfg_load_done_i | input | 1 | Configuration load finished |

## Verification
The outputs have different latencies. `arr_start_o` and the operand outputs are combinational in the accept cycle, so the bench samples them 1 ns after driving the command. The stall and the load request begin in the first cycle after acceptance. `rd_valid_o` and `err_o` appear one cycle after acceptance. The bench drives inputs on the falling edge and samples on the following falling edge. It counts the stalled cycles one by one and compares the total with the expected swap latency, load wait or budget. It changes `arr_result_i` every stalled cycle, so a capture that comes one cycle early or late returns the wrong word.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_SEL  = 2'd1,
    CMD_PUSH = 2'd2,
    CMD_PULL = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    CF_IDLE,
    CF_SWAP,
    CF_LOAD
  } cfg_st_e;
endpackage

// File: rtl/cpa_cfg_track.sv
module cpa_cfg_track
  import cpa_pkg::*;
#(
  parameter int CFG_W    = 4,
  parameter int NCACHE   = 4,
  parameter int SWAP_LAT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [CFG_W-1:0] tag_i,
  input  logic             load_done_i,
  output logic             busy_o,
  output logic             act_vld_o,
  output logic [CFG_W-1:0] act_tag_o,
  output logic             load_req_o,
  output logic [CFG_W-1:0] load_tag_o
);
  localparam int IDX_W = (NCACHE > 1) ? $clog2(NCACHE) : 1;
  localparam int SC_W  = $clog2(SWAP_LAT + 1);

  cfg_st_e                      st_q;
  logic [CFG_W-1:0]             act_q, pend_q;
  logic                         act_vld_q;
  logic [NCACHE-1:0][CFG_W-1:0] tag_q;
  logic [NCACHE-1:0]            vld_q;
  logic [NCACHE-1:0]            hit;
  logic [IDX_W-1:0]             hit_idx, idx_q, rr_q;
  logic [SC_W-1:0]              sc_q;
  logic                         act_hit, hit_any;

  for (genvar g = 0; g < NCACHE; g++) begin : g_hit
    assign hit[g] = vld_q[g] && (tag_q[g] == tag_i);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NCACHE - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit_any = |hit;
  assign act_hit = act_vld_q && (act_q == tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= CF_IDLE;
      act_q     <= '0;
      act_vld_q <= 1'b0;
      pend_q    <= '0;
      tag_q     <= '0;
      vld_q     <= '0;
      idx_q     <= '0;
      rr_q      <= '0;
      sc_q      <= '0;
    end else begin
      unique case (st_q)
        CF_IDLE: begin
          if (sel_i && !act_hit) begin
            pend_q <= tag_i;
            if (hit_any) begin
              st_q  <= CF_SWAP;
              idx_q <= hit_idx;
              sc_q  <= SC_W'(SWAP_LAT - 1);
            end else begin
              st_q <= CF_LOAD;
            end
          end
        end
        CF_SWAP: begin
          if (sc_q == '0) begin
            tag_q[idx_q] <= act_q;
            act_q        <= pend_q;
            st_q         <= CF_IDLE;
          end else begin
            sc_q <= sc_q - 1'b1;
          end
        end
        CF_LOAD: begin
          if (load_done_i) begin
            if (act_vld_q) begin
              tag_q[rr_q] <= act_q;
              vld_q[rr_q] <= 1'b1;
              rr_q        <= (rr_q == IDX_W'(NCACHE - 1)) ? '0 : rr_q + 1'b1;
            end
            act_q     <= pend_q;
            act_vld_q <= 1'b1;
            st_q      <= CF_IDLE;
          end
        end
        default: st_q <= CF_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != CF_IDLE);
  assign act_vld_o  = act_vld_q;
  assign act_tag_o  = act_q;
  assign load_req_o = (st_q == CF_LOAD);
  assign load_tag_o = pend_q;
endmodule

// File: rtl/cpa_op_timer.sv
module cpa_op_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cycles_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] res_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      res_q <= '0;
    end else if (start_i) begin
      cnt_q <= cycles_i;
      if (cycles_i == '0) res_q <= result_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      // capture on the final busy cycle
      if (cnt_q == CNT_W'(1)) res_q <= result_i;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign res_o  = res_q;
endmodule

// File: rtl/cpa_issue_ctrl.sv
module cpa_issue_ctrl
  import cpa_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CFG_W    = 4,
  parameter int CNT_W    = 16,
  parameter int NCACHE   = 4,
  parameter int SWAP_LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [CFG_W-1:0]  cmd_cfg_i,
  input  logic [DATA_W-1:0] cmd_a_i,
  input  logic [DATA_W-1:0] cmd_b_i,
  input  logic [CNT_W-1:0]  cmd_cycles_i,
  output logic              stall_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              arr_start_o,
  output logic [CFG_W-1:0]  arr_cfg_o,
  output logic [DATA_W-1:0] arr_op_a_o,
  output logic [DATA_W-1:0] arr_op_b_o,
  input  logic [DATA_W-1:0] arr_result_i,
  output logic              cfg_load_req_o,
  output logic [CFG_W-1:0]  cfg_load_tag_o,
  input  logic              cfg_load_done_i
);
  cmd_e              op;
  logic              acc, sel_acc, push_acc, pull_acc, data_bad;
  logic              cfg_busy, op_busy, act_vld;
  logic [CFG_W-1:0]  act_tag;
  logic [DATA_W-1:0] res;
  logic              rd_valid_q, err_q;
  logic [DATA_W-1:0] rd_data_q;

  assign op       = cmd_e'(cmd_op_i);
  assign stall_o  = cfg_busy | op_busy;
  assign acc      = cmd_valid_i & ~stall_o;
  assign sel_acc  = acc && (op == CMD_SEL);
  assign push_acc = acc && (op == CMD_PUSH) && act_vld;
  assign pull_acc = acc && (op == CMD_PULL) && act_vld;
  assign data_bad = acc && ((op == CMD_PUSH) || (op == CMD_PULL)) && !act_vld;

  cpa_cfg_track #(
    .CFG_W   (CFG_W),
    .NCACHE  (NCACHE),
    .SWAP_LAT(SWAP_LAT)
  ) cfg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_acc),
    .tag_i      (cmd_cfg_i),
    .load_done_i(cfg_load_done_i),
    .busy_o     (cfg_busy),
    .act_vld_o  (act_vld),
    .act_tag_o  (act_tag),
    .load_req_o (cfg_load_req_o),
    .load_tag_o (cfg_load_tag_o)
  );

  cpa_op_timer #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) tmr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (push_acc),
    .cycles_i(cmd_cycles_i),
    .result_i(arr_result_i),
    .busy_o  (op_busy),
    .res_o   (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      err_q      <= 1'b0;
    end else begin
      rd_valid_q <= pull_acc;
      if (pull_acc) rd_data_q <= res;
      if (data_bad) err_q <= 1'b1;
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign err_o       = err_q;
  assign arr_start_o = push_acc;
  assign arr_cfg_o   = act_tag;
  assign arr_op_a_o  = cmd_a_i;
  assign arr_op_b_o  = cmd_b_i;
endmodule

module cpa_issue_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cmd_cycles_i,
  input logic             stall_o,
  input logic             err_o,
  input logic             rd_valid_o,
  input logic             arr_start_o,
  input logic             cfg_load_req_o,
  input logic             cfg_load_done_i
);
  // R7
  stall_after_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_start_o && cmd_cycles_i != '0) |=> stall_o);
  // R2
  no_start_in_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_start_o |-> !stall_o);
  // R5
  load_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_req_o |-> stall_o);
  // R5
  load_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_load_req_o && !cfg_load_done_i) |=> cfg_load_req_o);
  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R9
  rd_after_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !$past(stall_o));
endmodule

bind cpa_issue_ctrl cpa_issue_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_cycles_i   (cmd_cycles_i),
  .stall_o        (stall_o),
  .err_o          (err_o),
  .rd_valid_o     (rd_valid_o),
  .arr_start_o    (arr_start_o),
  .cfg_load_req_o (cfg_load_req_o),
  .cfg_load_done_i(cfg_load_done_i)
);

// File: tb/cpa_issue_ctrl_tb_top.sv
module cpa_issue_ctrl_tb_top;
  localparam int DW = 32, CW = 4, NW = 16, NC = 4, SL = 4, LOAD_WAIT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [CW-1:0] cmd_cfg;
  logic [DW-1:0] cmd_a, cmd_b, arr_result, rd_data, op_a, op_b;
  logic [NW-1:0] cmd_cycles;
  logic          stall, err, rd_valid, arr_start, load_req, load_done;
  logic [CW-1:0] arr_cfg, load_tag;

  always #4 clk = ~clk;

  cpa_issue_ctrl #(.DATA_W(DW), .CFG_W(CW), .CNT_W(NW), .NCACHE(NC), .SWAP_LAT(SL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_cfg_i(cmd_cfg), .cmd_a_i(cmd_a), .cmd_b_i(cmd_b), .cmd_cycles_i(cmd_cycles),
    .stall_o(stall), .err_o(err), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .arr_start_o(arr_start), .arr_cfg_o(arr_cfg), .arr_op_a_o(op_a), .arr_op_b_o(op_b),
    .arr_result_i(arr_result), .cfg_load_req_o(load_req), .cfg_load_tag_o(load_tag),
    .cfg_load_done_i(load_done)
  );

  int n_run = 0, n_fail = 0;
  bit            m_act_v;
  logic [CW-1:0] m_act;
  logic [CW-1:0] m_c[NC];
  bit            m_cv[NC];
  int            m_rr;
  logic [DW-1:0] m_res;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sel_kind(logic [CW-1:0] t);
    if (m_act_v && m_act == t) return 0;
    for (int i = 0; i < NC; i++) if (m_cv[i] && m_c[i] == t) return 1;
    return 2;
  endfunction

  function automatic void sel_update(logic [CW-1:0] t, int kind);
    if (kind == 1) begin
      for (int i = 0; i < NC; i++)
        if (m_cv[i] && m_c[i] == t) begin m_c[i] = m_act; break; end
      m_act = t;
    end else if (kind == 2) begin
      if (m_act_v) begin m_c[m_rr] = m_act; m_cv[m_rr] = 1'b1; m_rr = (m_rr + 1) % NC; end
      m_act = t; m_act_v = 1'b1;
    end
  endfunction

  function automatic int sel_stall(int kind);
    return (kind == 0) ? 0 : (kind == 1) ? SL : LOAD_WAIT;
  endfunction

  task automatic idle_cmd();
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  task automatic do_sel(logic [CW-1:0] t);
    int kind = sel_kind(t);
    int n = 0;
    bit lr = 0;
    logic [CW-1:0] lt = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_cfg = t;
    @(posedge clk);
    @(negedge clk);
    idle_cmd();
    while (stall) begin
      n++;
      if (load_req) begin lr = 1; lt = load_tag; end
      load_done = load_req && (n == LOAD_WAIT);
      @(negedge clk);
    end
    load_done = 1'b0;
    case (kind)
      0: chk(n == 0, "R3", "active select stall", n, 0);
      1: chk(n == SL, "R4", "cached swap stall", n, SL);
      default: begin
        chk(n == LOAD_WAIT, "R5", "miss load stall", n, LOAD_WAIT);
        chk(lr && lt == t, "R5", "load request tag", lt, t);
      end
    endcase
    if (kind != 2) chk(!lr, "R4", "no load request on hit", lr, 0);
    sel_update(t, kind);
    chk(arr_cfg == t, (kind == 1) ? "R4" : "R5", "active tag", arr_cfg, t);
  endtask

  task automatic do_push(logic [DW-1:0] a, logic [DW-1:0] b, int c);
    int n = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_a = a; cmd_b = b; cmd_cycles = NW'(c);
    arr_result = $urandom; m_res = arr_result;
    #1;
    chk(arr_start == 1'b1, "R6", "start pulse", arr_start, 1);
    chk(op_a == a && op_b == b, "R6", "operand a", op_a, a);
    chk(arr_cfg == m_act, "R6", "config tag", arr_cfg, m_act);
    @(posedge clk);
    @(negedge clk);
    idle_cmd();
    while (stall) begin
      n++;
      arr_result = $urandom; m_res = arr_result;
      @(negedge clk);
    end
    chk(n == c, "R7", "operation stall cycles", n, c);
  endtask

  task automatic do_pull();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3;
    @(posedge clk);
    @(negedge clk);
    idle_cmd();
    chk(rd_valid == 1'b1, "R8", "read valid", rd_valid, 1);
    chk(rd_data == m_res, "R8", "read data", rd_data, m_res);
  endtask

  task automatic held_pull(int c);
    int n = 0;
    bit early = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_a = $urandom; cmd_b = $urandom; cmd_cycles = NW'(c);
    arr_result = $urandom; m_res = arr_result;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 2'd3;
    while (stall) begin
      n++;
      if (rd_valid) early = 1;
      arr_result = $urandom; m_res = arr_result;
      @(negedge clk);
    end
    chk(!early, "R9", "no read while stalled", early, 0);
    chk(n == c, "R9", "stall extended to expiry", n, c);
    @(posedge clk);
    @(negedge clk);
    idle_cmd();
    chk(rd_valid == 1'b1, "R9", "held read valid", rd_valid, 1);
    chk(rd_data == m_res, "R9", "held read data", rd_data, m_res);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_act_v = 0; m_act = '0; m_rr = 0; m_res = '0;
    for (int i = 0; i < NC; i++) begin m_c[i] = '0; m_cv[i] = 0; end
    rst_n = 1'b0; idle_cmd(); cmd_cfg = '0; cmd_a = '0; cmd_b = '0; cmd_cycles = '0;
    arr_result = '0; load_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !err && !load_req && !rd_valid, "R1", "reset outputs", {stall, err, load_req, rd_valid}, 0);

    // R11: data commands with nothing resident
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_cycles = 16'd5;
    #1 chk(arr_start == 1'b0, "R11", "no start without config", arr_start, 0);
    @(posedge clk); @(negedge clk);
    cmd_op = 2'd3;
    chk(err == 1'b1, "R11", "error set", err, 1);
    chk(stall == 1'b0, "R1", "no stall from dropped push", stall, 0);
    @(posedge clk); @(negedge clk);
    idle_cmd();
    chk(rd_valid == 1'b0, "R11", "dropped pull no valid", rd_valid, 0);

    // residency directed sequence R3/R4/R5
    do_sel(4'd1);
    do_sel(4'd1);
    do_sel(4'd2);
    do_sel(4'd1);
    do_sel(4'd2);
    for (int t = 3; t < 9; t++) do_sel(CW'(t));
    do_sel(4'd1);
    do_sel(4'd2);

    // R7/R8 corner budgets
    do_push(32'hdead_beef, 32'h1234_5678, 0); do_pull();
    do_push(32'h1, 32'h2, 1); do_pull();
    do_push(32'h3, 32'h4, 7); do_pull();
    // R10: result stays put
    repeat (5) @(negedge clk);
    do_pull();
    do_pull();
    held_pull(6);
    held_pull(1);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int r = $urandom % 3;
      if (r == 0) do_sel(CW'($urandom % 9));
      else if (r == 1) do_push($urandom, $urandom, $urandom % 25);
      else do_pull();
    end

    chk(err == 1'b1, "R11", "error still sticky", err, 1);
    summary();
    $finish;
  end
endmodule